// File: doc/BRIEF.md
# Status Register and Block-Protect Unit

This unit keeps the control state of a small serial memory: the write-enable latch, the write-in-progress flag and a two-bit block-protect level. It takes one-cycle command strobes from the command decoder. These are set-enable, clear-enable and status-write, which carries a new protect level. It also takes a start strobe and a completion pulse for the internal write cycle. It presents the status byte that the read-status command shifts out.

It also answers the question the page-write unit asks before it programs a byte: is the byte at this 9-bit address read-only under the current protect level? The array is 512 bytes. The protect level can lock the top quarter, the top half or the whole array. The reset value of the protect level stands in for its nonvolatile retention.

A status write behaves like an ordinary programming operation. It needs the latch set and the write-protect input high. It occupies a timed write cycle. The new protect level takes effect when that cycle completes. Completing any write cycle clears the latch.

Top module: `sr_status_unit`

## Requirements
- R1: After reset the status byte is 0x00, with the enable latch clear, the unit idle and the protect level equal to parameter BP_RST (default 00).
- R2: A set-enable strobe with wp_ni high while idle sets the enable latch. From the next cycle, status bit 1 reads 1.
- R3: A set-enable strobe while wp_ni is low leaves the enable latch unchanged.
- R4: A clear-enable strobe while idle clears the enable latch whatever the level of wp_ni.
- R5: While idle, the status byte is {4'b0000, bp[1], bp[0], wen, 1'b0}.
- R6: While a write cycle is in progress, all eight status bits read 1 (0xFF).
- R7: An accepted status-write or memory-write start begins a write cycle, which lasts until wr_done_i. After that cycle the unit is idle with the enable latch clear. A memory-write start needs the latch set and wp_ni high.
- R8: A status-write strobe is accepted only when the latch is set, wp_ni is high and the unit is idle. The new level from bp_wr_i appears only after the cycle completes. A rejected strobe leaves the level unchanged.
- R9: While a write cycle is in progress, set-enable, clear-enable, status-write and memory-write start strobes have no effect.
- R10: prot_o is 1 for these addresses and levels: none at level 00, 0x180–0x1FF at 01, 0x100–0x1FF at 10, and every address at 11.
- R11: prot_o follows chk_addr_i and the current level combinationally, in the same cycle, with no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wp_ni | input | 1 | Write-protect input; low blocks set-enable, status-write and memory-write start |
| wren_i | input | 1 | Set-enable strobe |
| wrdi_i | input | 1 | Clear-enable strobe |
| wrsr_i | input | 1 | Status-write strobe |
| bp_wr_i | input | 2 | Protect level carried by the status write |
| mem_wr_start_i | input | 1 | Page-write unit requests a memory write cycle |
| wr_done_i | input | 1 | Write cycle complete pulse |
| chk_addr_i | input | 9 | Byte address to test against the protect level |
| prot_o | output | 1 | Address is read-only |
| wen_o | output | 1 | Enable latch |
| busy_o | output | 1 | Write cycle in progress |
| bp_o | output | 2 | Current protect level |
| status_o | output | 8 | Status byte for the read-status command |

## Verification
Some properties are checked on every cycle. One is the fixed format of the status byte when idle and when busy. Others are the effect of each command strobe one cycle later, the clearing of the latch and the busy flag at completion, and the rule that the protect level changes only at a completion. The extreme protect levels are also checked at all times. Other behaviour only the bench scenarios can show. These are the late commit of a status write, the ignoring of strobes during a cycle and refused status writes. They also include the exact quarter and half boundaries of the protect map at each level.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int unsigned BP_W   = 2;
  localparam int unsigned STAT_W = 8;
  typedef logic [BP_W-1:0] bp_t;
endpackage

// File: rtl/sr_wel.sv
module sr_wel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic wen_o
);
  // clear wins over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wen_o <= 1'b0;
    else if (clr_i)  wen_o <= 1'b0;
    else if (set_i)  wen_o <= 1'b1;
  end
endmodule

// File: rtl/sr_cycle.sv
module sr_cycle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_o <= 1'b0;
    else if (done_i)   busy_o <= 1'b0;
    else if (start_i)  busy_o <= 1'b1;
  end
endmodule

// File: rtl/sr_bp_reg.sv
module sr_bp_reg
  import sr_pkg::*;
#(
  parameter bp_t BP_RST = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  bp_t  new_i,
  input  logic commit_i,
  output bp_t  bp_o
);
  bp_t  pend_q;
  logic pend_vld_q;

  // new level is staged and applied only at end of write cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_o       <= BP_RST;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else if (load_i) begin
      pend_q     <= new_i;
      pend_vld_q <= 1'b1;
    end else if (commit_i) begin
      if (pend_vld_q) bp_o <= pend_q;
      pend_vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sr_prot_dec.sv
module sr_prot_dec
  import sr_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  bp_t               bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam logic [ADDR_W-1:0] QTR  = ADDR_W'(1) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] TOPQ = QTR * 3;
  localparam logic [ADDR_W-1:0] TOPH = QTR * 2;

  logic [ADDR_W-1:0] base;
  always_comb begin
    unique case (bp_i)
      2'b01:   base = TOPQ;
      2'b10:   base = TOPH;
      default: base = '0;
    endcase
    prot_o = (bp_i != 2'b00) && (addr_i >= base);
  end
endmodule

// File: rtl/sr_status_unit.sv
module sr_status_unit
  import sr_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter logic [1:0]  BP_RST = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [1:0]        bp_wr_i,
  input  logic              mem_wr_start_i,
  input  logic              wr_done_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              prot_o,
  output logic              wen_o,
  output logic              busy_o,
  output logic [1:0]        bp_o,
  output logic [7:0]        status_o
);
  logic idle, wren_ok, wrdi_ok, wrsr_ok, mem_ok, done;

  always_comb begin
    idle    = ~busy_o;
    wren_ok = wren_i & wp_ni & idle & ~wrdi_i;
    wrdi_ok = wrdi_i & idle;
    wrsr_ok = wrsr_i & wen_o & wp_ni & idle;
    mem_ok  = mem_wr_start_i & wen_o & wp_ni & idle & ~wrsr_i;
    done    = wr_done_i & busy_o;
  end

  sr_wel u_wel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wren_ok),
    .clr_i  (wrdi_ok | done),
    .wen_o  (wen_o)
  );

  sr_cycle u_cycle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wrsr_ok | mem_ok),
    .done_i  (done),
    .busy_o  (busy_o)
  );

  sr_bp_reg #(.BP_RST(BP_RST)) u_bp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wrsr_ok),
    .new_i    (bp_wr_i),
    .commit_i (done),
    .bp_o     (bp_o)
  );

  sr_prot_dec #(.ADDR_W(ADDR_W)) u_dec (
    .bp_i   (bp_o),
    .addr_i (chk_addr_i),
    .prot_o (prot_o)
  );

  always_comb begin
    if (busy_o) status_o = '1;
    else        status_o = {4'b0000, bp_o, wen_o, 1'b0};
  end
endmodule

// File: rtl/sr_status_unit_chk.sv
module sr_status_unit_chk #(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wp_ni,
  input logic              wren_i,
  input logic              wrdi_i,
  input logic              wrsr_i,
  input logic              wr_done_i,
  input logic [ADDR_W-1:0] chk_addr_i,
  input logic              prot_o,
  input logic              wen_o,
  input logic              busy_o,
  input logic [1:0]        bp_o,
  input logic [7:0]        status_o
);
  p_busy_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> status_o == 8'hFF);

  p_idle_fmt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (status_o[7:4] == 4'h0 && status_o[0] == 1'b0 &&
                 status_o[3:2] == bp_o && status_o[1] == wen_o));

  p_wren_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_i && wp_ni && !busy_o && !wrdi_i) |=> wen_o);

  p_wren_wp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_i && !wp_ni && !wen_o) |=> !wen_o);

  p_wrdi_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrdi_i && !busy_o) |=> !wen_o);

  p_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_done_i) |=> (!busy_o && !wen_o));

  p_bp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && wr_done_i) |=> $stable(bp_o));

  p_busy_wen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wr_done_i) |=> $stable(wen_o));

  p_lvl_all_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_o == 2'b11) |-> prot_o);

  p_lvl_none_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_o == 2'b00) |-> !prot_o);

  p_top_addr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_o != 2'b00 && chk_addr_i == '1) |-> prot_o);
endmodule

bind sr_status_unit sr_status_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sr_status_unit_test.sv
`timescale 1ns/1ps
module sr_status_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wp_ni = 1'b1;
  logic       wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0;
  logic [1:0] bp_wr_i = 2'b00;
  logic       mem_wr_start_i = 1'b0, wr_done_i = 1'b0;
  logic [8:0] chk_addr_i = '0;
  logic       prot_o, wen_o, busy_o;
  logic [1:0] bp_o;
  logic [7:0] status_o;

  int errors = 0;
  int checks = 0;
  bit done_flag = 1'b0;

  // model state, from the requirements
  logic       m_wen = 1'b0, m_busy = 1'b0;
  logic [1:0] m_bp = 2'b00, m_pend = 2'b00;
  bit         m_pend_v = 1'b0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  always #2.5 clk_i = ~clk_i;

  sr_status_unit uut (.*);

  function automatic logic [7:0] model_status();
    return m_busy ? 8'hFF : {4'b0000, m_bp, m_wen, 1'b0};
  endfunction

  task automatic push_exp(input string req);
    exp_q.push_back(model_status());
    req_q.push_back(req);
  endtask

  // monitor: compares status after each edge against queued expectations
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        checks++;
        if (status_o !== e) begin
          errors++;
          $display("FAIL %s status actual=%02h expected=%02h", r, status_o, e);
        end
      end
    end
  end

  // driver: one strobe cycle, model update, expectation push
  task automatic op(input string kind, input logic wp, input logic [1:0] bp, input string req);
    @(negedge clk_i);
    wp_ni = wp;
    bp_wr_i = bp;
    case (kind)
      "wren": wren_i = 1'b1;
      "wrdi": wrdi_i = 1'b1;
      "wrsr": wrsr_i = 1'b1;
      "mem":  mem_wr_start_i = 1'b1;
      "done": wr_done_i = 1'b1;
      default: ;
    endcase
    if (!m_busy) begin
      case (kind)
        "wren": if (wp) m_wen = 1'b1;
        "wrdi": m_wen = 1'b0;
        "wrsr": if (wp && m_wen) begin m_busy = 1'b1; m_pend = bp; m_pend_v = 1'b1; end
        "mem":  if (wp && m_wen) m_busy = 1'b1;
        default: ;
      endcase
    end else if (kind == "done") begin
      m_busy = 1'b0;
      m_wen = 1'b0;
      if (m_pend_v) m_bp = m_pend;
      m_pend_v = 1'b0;
    end
    push_exp(req);
    @(negedge clk_i);
    wren_i = 1'b0; wrdi_i = 1'b0; wrsr_i = 1'b0;
    mem_wr_start_i = 1'b0; wr_done_i = 1'b0;
    wp_ni = 1'b1;
  endtask

  task automatic chk_prot(input logic [8:0] a, input string req);
    logic e;
    chk_addr_i = a;
    #0.5;
    e = (m_bp == 2'b11) || (m_bp == 2'b10 && a[8]) || (m_bp == 2'b01 && a[8:7] == 2'b11);
    checks++;
    if (prot_o !== e) begin
      errors++;
      $display("FAIL %s prot addr=%03h lvl=%0d actual=%0b expected=%0b", req, a, m_bp, prot_o, e);
    end
  endtask

  task automatic set_level(input logic [1:0] lvl);
    op("wren", 1'b1, 2'b00, "R2");
    op("wrsr", 1'b1, lvl, "R8");
    op("done", 1'b1, 2'b00, "R8");
  endtask

  initial begin
    #12;
    rst_ni = 1'b1;
    @(negedge clk_i);
    push_exp("R1");                     // reset state 0x00
    op("wren", 1'b0, 2'b00, "R3");      // blocked by wp low
    op("wren", 1'b1, 2'b00, "R2");      // 0x02
    op("wrdi", 1'b0, 2'b00, "R4");      // clears regardless of wp
    op("wren", 1'b1, 2'b00, "R5");
    op("wrsr", 1'b1, 2'b01, "R6");      // busy: 0xFF
    op("wren", 1'b1, 2'b00, "R9");
    op("wrdi", 1'b1, 2'b00, "R9");
    op("wrsr", 1'b1, 2'b11, "R9");
    op("done", 1'b1, 2'b00, "R8");      // level 01, wen clear: 0x04
    op("wrsr", 1'b1, 2'b10, "R8");      // wen=0: refused
    op("wren", 1'b1, 2'b00, "R2");
    op("wrsr", 1'b0, 2'b10, "R8");      // wp low: refused
    op("mem",  1'b1, 2'b00, "R7");      // busy
    op("mem",  1'b1, 2'b00, "R9");
    op("done", 1'b1, 2'b00, "R7");      // 0x04
    op("mem",  1'b1, 2'b00, "R7");      // wen=0: no cycle
    op("done", 1'b1, 2'b00, "R7");      // stray done while idle
    for (int lvl = 0; lvl < 4; lvl++) begin
      set_level(2'(lvl));
      chk_prot(9'h000, "R10");
      chk_prot(9'h0FF, "R10");
      chk_prot(9'h100, "R10");
      chk_prot(9'h17F, "R10");
      chk_prot(9'h180, "R10");
      chk_prot(9'h1FF, "R11");
    end
    op("wren", 1'b1, 2'b00, "R5");      // level 11 plus wen: 0x0E
    repeat (3) @(negedge clk_i);
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule